// File: doc/BRIEF.md
# Speculative Write Backup Buffer

This block tracks the cache lines that a local speculative region has put under protection. It is a small fully associative table. Each slot records a line address, whether the line is held shared (read-protected) or owned (write-protected), and a saved copy of the line's data as it stood before the region first stored to it. The local core sends protect requests (protected load, protected store, prefetch for read, prefetch for write, release), a commit strobe, and the addresses of its non-speculative stores. Remote coherence probes are snooped against every slot in a single cycle.

A probe that conflicts with a protected line aborts the local region, since the requester always wins. Before that probe is acknowledged, the block streams every saved line copy back toward memory, one per cycle. When a protect request needs a fresh slot and none is free, the region also aborts, and the saved copies are streamed out in the same way. A commit clears the whole table at once.

Top module: `spec_backup_buf`

## Requirements
- R1: After reset the table is empty. `abort`, `abort_cause`, `wb_valid` and `nsst_fault` are low, and a probe of any kind is acknowledged in the cycle it is presented.
- R2: A probe of kind read (0) or prefetch (2) that hits a line held shared is acknowledged in the same cycle and raises no abort. A protected load (op 0) or prefetch for read (op 2) leaves a line shared when it was not already owned.
- R3: A probe of kind read (0) or prefetch (2) that hits a line held owned is not acknowledged in that cycle. In the next cycle `abort` pulses high for one cycle with `abort_cause` = 1. A line becomes owned through a protected store (op 1) or a prefetch for write (op 3).
- R4: A probe of kind write (1) or prefetch for write (3) that hits any protected line causes the abort of R3.
- R5: After an abort, `wb_valid` is high for exactly one cycle per line that holds a speculative store. These lines come out in ascending slot order, and slots are allocated lowest free first. The conflicting probe is acknowledged in the cycle after the last write-back, or in the abort cycle itself when there is nothing to write back. The table is then empty.
- R6: The saved copy of a line is the `req_data` of the first protected store to that line. Later stores to the same line do not replace it.
- R7: A release (op 4) removes a line that holds no speculative store, so a later write probe to that line is acknowledged without an abort. A release has no effect on a line that holds a speculative store.
- R8: A non-speculative store whose address matches a line that holds a speculative store raises `nsst_fault` for one cycle, in the next cycle. A match with any other line, or no match, raises nothing.
- R9: A commit empties the table in one cycle and writes nothing back.
- R10: A protect request that needs a new slot while all slots are valid aborts with `abort_cause` = 2 and writes back every saved copy as in R5. No probe acknowledge is tied to this abort.
- R11: When a conflicting probe and a protect request or a commit arrive in the same cycle, the probe wins. The request or the commit is dropped.
- R12: Protect requests and commits presented while a write-back is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local protect request present |
| req_op | input | 3 | 0 load, 1 store, 2 prefetch read, 3 prefetch write, 4 release |
| req_addr | input | LADDR_W | Line address of the request |
| req_data | input | LINE_W | Line contents before the store (captured as the saved copy) |
| commit | input | 1 | End the region successfully and clear the table |
| nsst_valid | input | 1 | Non-speculative store present |
| nsst_addr | input | LADDR_W | Line address of the non-speculative store |
| nsst_fault | output | 1 | Exception: non-speculative store to a speculatively written line |
| probe_valid | input | 1 | Remote probe present, held until acknowledged |
| probe_kind | input | 2 | 0 read, 1 write, 2 prefetch, 3 prefetch for write |
| probe_addr | input | LADDR_W | Line address of the probe |
| probe_ack | output | 1 | Probe may now be answered |
| abort | output | 1 | One-cycle abort pulse |
| abort_cause | output | 2 | 1 conflict, 2 capacity; valid with `abort` |
| wb_valid | output | 1 | Saved copy being written back |
| wb_addr | output | LADDR_W | Line address of the write-back |
| wb_data | output | LINE_W | Saved line contents |

## Verification
The bench targets the cycle in which a snooped conflict and a local protect request or commit arrive together. It holds a write probe on a protected line while it issues a store to a new line in that same cycle. The behavioural model predicts that the abort wins and the store is lost. This is then judged at the ports: the dropped line is absent from the write-back stream, and a later write probe to it is acknowledged without a second abort. Requests sent during the write-back stream are judged the same way.

// File: rtl/spec_backup_buf.sv
module spec_backup_buf #(
  parameter int ENTRIES = 8,
  parameter int LADDR_W = 26,
  parameter int LINE_W  = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0]  req_data,
  input  logic               commit,
  input  logic               nsst_valid,
  input  logic [LADDR_W-1:0] nsst_addr,
  output logic               nsst_fault,
  input  logic               probe_valid,
  input  logic [1:0]         probe_kind,
  input  logic [LADDR_W-1:0] probe_addr,
  output logic               probe_ack,
  output logic               abort,
  output logic [1:0]         abort_cause,
  output logic               wb_valid,
  output logic [LADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0]  wb_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_PR = 3'd2, OP_PW = 3'd3, OP_REL = 3'd4;
  localparam logic [1:0] PK_WR = 2'd1, PK_PFW = 2'd3;
  localparam logic [1:0] CAUSE_CONFLICT = 2'd1, CAUSE_CAP = 2'd2;

  logic [ENTRIES-1:0] vld, own, dirty, wb_mask;
  logic [LADDR_W-1:0] tag [ENTRIES];
  logic [LINE_W-1:0]  bkp [ENTRIES];
  logic               restoring, ack_due;

  logic [ENTRIES-1:0] req_hit, prb_hit, ns_hit;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cam
      assign req_hit[g] = vld[g] && tag[g] == req_addr;
      assign prb_hit[g] = vld[g] && tag[g] == probe_addr;
      assign ns_hit[g]  = vld[g] && tag[g] == nsst_addr;
    end
  endgenerate

  logic [IDX_W-1:0] hit_idx, free_idx, wb_idx;
  logic             have_free;

  always_comb begin
    hit_idx = '0;
    free_idx = '0;
    wb_idx = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req_hit[i]) hit_idx = IDX_W'(i);
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        have_free = 1'b1;
      end
      if (wb_mask[i]) wb_idx = IDX_W'(i);
    end
  end

  wire write_probe  = probe_kind == PK_WR || probe_kind == PK_PFW;
  wire prb_conflict = !restoring && probe_valid &&
                      |(prb_hit & (write_probe ? vld : own));
  wire req_any_hit  = |req_hit;
  wire need_slot    = req_valid && !req_any_hit && req_op <= OP_PW;
  wire cap_ovf      = !restoring && !commit && need_slot && !have_free;
  wire wb_busy      = |wb_mask;

  assign probe_ack = probe_valid && (restoring ? (!wb_busy && ack_due) : !prb_conflict);
  assign wb_valid  = restoring && wb_busy;
  assign wb_addr   = tag[wb_idx];
  assign wb_data   = bkp[wb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      own <= '0;
      dirty <= '0;
      wb_mask <= '0;
      restoring <= 1'b0;
      ack_due <= 1'b0;
      abort <= 1'b0;
      abort_cause <= '0;
      nsst_fault <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        bkp[i] <= '0;
      end
    end else begin
      abort <= 1'b0;
      abort_cause <= '0;
      nsst_fault <= nsst_valid && |(ns_hit & dirty);
      if (restoring) begin
        if (wb_busy) begin
          wb_mask[wb_idx] <= 1'b0;
        end else begin
          restoring <= 1'b0;
          ack_due <= 1'b0;
          vld <= '0;
          own <= '0;
          dirty <= '0;
        end
      end else if (prb_conflict) begin
        abort <= 1'b1;
        abort_cause <= CAUSE_CONFLICT;
        restoring <= 1'b1;
        ack_due <= 1'b1;
        wb_mask <= vld & dirty;
      end else if (commit) begin
        vld <= '0;
        own <= '0;
        dirty <= '0;
      end else if (cap_ovf) begin
        abort <= 1'b1;
        abort_cause <= CAUSE_CAP;
        restoring <= 1'b1;
        ack_due <= 1'b0;
        wb_mask <= vld & dirty;
      end else if (req_valid) begin
        if (need_slot) begin
          vld[free_idx] <= 1'b1;
          tag[free_idx] <= req_addr;
          own[free_idx] <= req_op == OP_ST || req_op == OP_PW;
          dirty[free_idx] <= req_op == OP_ST;
          if (req_op == OP_ST) bkp[free_idx] <= req_data;
        end else if (req_any_hit) begin
          case (req_op)
            OP_ST: begin
              own[hit_idx] <= 1'b1;
              if (!dirty[hit_idx]) begin
                dirty[hit_idx] <= 1'b1;
                bkp[hit_idx] <= req_data;
              end
            end
            OP_PW: own[hit_idx] <= 1'b1;
            OP_REL: if (!dirty[hit_idx]) begin
              vld[hit_idx] <= 1'b0;
              own[hit_idx] <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module spec_backup_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       probe_valid,
  input logic       probe_ack,
  input logic       abort,
  input logic [1:0] abort_cause,
  input logic       wb_valid
);
  // R2
  ack_needs_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_ack |-> probe_valid);
  // R5
  no_ack_during_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !probe_ack);
  // R4
  abort_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  // R10
  abort_cause_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (abort_cause == 2'd1 || abort_cause == 2'd2));
  // R3
  cause_only_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort |-> abort_cause == 2'd0);
endmodule

bind spec_backup_buf spec_backup_buf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .probe_valid(probe_valid), .probe_ack(probe_ack),
  .abort(abort), .abort_cause(abort_cause), .wb_valid(wb_valid)
);

// File: tb/spec_backup_buf_test.sv
module spec_backup_buf_test;
  localparam int N = 8;
  localparam int AW = 26;
  localparam int DW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, commit = 0, nsst_valid = 0, probe_valid = 0;
  logic [2:0] req_op = 0;
  logic [1:0] probe_kind = 0;
  logic [AW-1:0] req_addr = 0, nsst_addr = 0, probe_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic probe_ack, abort, wb_valid, nsst_fault;
  logic [1:0] abort_cause;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  spec_backup_buf uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural model
  bit mv[N], mo[N], md[N];
  logic [AW-1:0] ma[N];
  logic [DW-1:0] mb[N];
  bit mrest = 0, mack = 0, mab = 0, mflt = 0;
  logic [1:0] mcause = 0;
  int wq[$];
  bit last_ack;

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic bit conflict();
    int h;
    if (mrest || !probe_valid) return 0;
    h = find(probe_addr);
    if (h < 0) return 0;
    return (probe_kind == 1 || probe_kind == 3) ? 1'b1 : mo[h];
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin mv[i] = 0; mo[i] = 0; md[i] = 0; end
  endtask

  task automatic start_abort(logic [1:0] c, bit ack);
    mab = 1; mcause = c; mrest = 1; mack = ack;
    wq.delete();
    for (int i = 0; i < N; i++) if (mv[i] && md[i]) wq.push_back(i);
  endtask

  task automatic model_update();
    bit cf = conflict();
    int h, f;
    h = find(nsst_addr);
    mflt = nsst_valid && h >= 0 && md[h];
    mab = 0; mcause = 0;
    if (mrest) begin
      if (wq.size() > 0) void'(wq.pop_front());
      else begin mrest = 0; mack = 0; clear_all(); end
    end else if (cf) start_abort(2'd1, 1);
    else if (commit) clear_all();
    else if (req_valid && req_op <= 4) begin
      h = find(req_addr);
      f = -1;
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) f = i;
      if (h < 0 && req_op != 4) begin
        if (f < 0) start_abort(2'd2, 0);
        else begin
          mv[f] = 1; ma[f] = req_addr;
          mo[f] = (req_op == 1 || req_op == 3);
          md[f] = (req_op == 1);
          if (req_op == 1) mb[f] = req_data;
        end
      end else if (h >= 0) begin
        if (req_op == 1) begin
          mo[h] = 1;
          if (!md[h]) begin md[h] = 1; mb[h] = req_data; end
        end else if (req_op == 3) mo[h] = 1;
        else if (req_op == 4 && !md[h]) begin mv[h] = 0; mo[h] = 0; end
      end
    end
  endtask

  task automatic tick();
    bit e_ack, e_wbv;
    logic [AW-1:0] e_wba;
    logic [DW-1:0] e_wbd;
    #4;
    e_wbv = mrest && wq.size() > 0;
    e_wba = e_wbv ? ma[wq[0]] : '0;
    e_wbd = e_wbv ? mb[wq[0]] : '0;
    e_ack = probe_valid && (mrest ? (wq.size() == 0 && mack) : !conflict());
    last_ack = e_ack;
    checks++;
    if (probe_ack !== e_ack || abort !== mab || abort_cause !== mcause ||
        wb_valid !== e_wbv || nsst_fault !== mflt ||
        (e_wbv && (wb_addr !== e_wba || wb_data !== e_wbd))) begin
      errors++;
      $display("FAIL %s t=%0t ack/abort/cause/wbv/flt/wba/wbd32 actual=%b %b %0d %b %b %h %h expected=%b %b %0d %b %b %h %h",
               cur_req, $time, probe_ack, abort, abort_cause, wb_valid, nsst_fault, wb_addr, wb_data[31:0],
               e_ack, mab, mcause, e_wbv, mflt, e_wba, e_wbd[31:0]);
    end
    model_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req(logic [2:0] op, logic [AW-1:0] a, logic [31:0] d);
    req_valid = 1; req_op = op; req_addr = a; req_data = {16{d}};
    tick();
    req_valid = 0;
  endtask

  task automatic probe(logic [1:0] k, logic [AW-1:0] a);
    probe_valid = 1; probe_kind = k; probe_addr = a;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (last_ack) break;
    end
    probe_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    clear_all();
    @(negedge clk); @(negedge clk);
    cur_req = "R1";
    checks++;
    if (abort !== 0 || wb_valid !== 0 || nsst_fault !== 0 || abort_cause !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b%b%b%0d expected=0000", abort, wb_valid, nsst_fault, abort_cause);
    end
    rst_n = 1;
    idle(2);
    probe(1, 26'h10);

    cur_req = "R2";
    req(0, 26'h100, 32'h0);
    req(2, 26'h101, 32'h0);
    probe(0, 26'h100);
    probe(2, 26'h101);
    probe(2, 26'h100);

    cur_req = "R6";
    req(1, 26'h200, 32'hAAAA0001);
    req(1, 26'h200, 32'hBBBB0002);
    req(3, 26'h201, 32'h0);
    cur_req = "R3";
    probe(0, 26'h201);
    cur_req = "R5";
    idle(2);
    probe(1, 26'h200);

    cur_req = "R8";
    req(0, 26'h300, 32'h0);
    req(1, 26'h301, 32'hCCCC0003);
    nsst_valid = 1; nsst_addr = 26'h301; tick();
    nsst_addr = 26'h300; tick();
    nsst_addr = 26'h999; tick();
    nsst_valid = 0; tick();
    cur_req = "R7";
    req(4, 26'h300, 32'h0);
    req(4, 26'h301, 32'h0);
    probe(1, 26'h300);
    cur_req = "R4";
    probe(3, 26'h301);

    cur_req = "R9";
    req(1, 26'h400, 32'h11110004);
    req(1, 26'h401, 32'h22220005);
    req(0, 26'h402, 32'h0);
    commit = 1; tick(); commit = 0;
    probe(1, 26'h400);
    probe(3, 26'h402);

    cur_req = "R10";
    for (int i = 0; i < N; i++) req(1, 26'h500 + i, 32'h5000 + i);
    req(0, 26'h600, 32'h0);
    cur_req = "R12";
    req(1, 26'h700, 32'h77770007);
    commit = 1; tick(); commit = 0;
    idle(N + 1);
    probe(1, 26'h700);
    probe(1, 26'h503);

    cur_req = "R11";
    req(0, 26'h800, 32'h0);
    req(1, 26'h801, 32'h88880008);
    probe_valid = 1; probe_kind = 1; probe_addr = 26'h800;
    req_valid = 1; req_op = 1; req_addr = 26'h802; req_data = {16{32'h99990009}};
    commit = 1;
    tick();
    req_valid = 0; commit = 0;
    probe(1, 26'h800);
    probe(1, 26'h802);
    probe(1, 26'h801);

    cur_req = "R5";
    req(1, 26'h900, 32'hD0D0000A);
    req(0, 26'h901, 32'h0);
    req(1, 26'h902, 32'hE0E0000B);
    probe(0, 26'h902);
    idle(2);
    report();
  end
endmodule